// File: doc/BRIEF.md
# Boot Address Remap and Pause Controller

This block sits on the request path between an upstream memory access port and a downstream memory bus. Straight after reset it runs in remap mode: each upstream address is compared against a small table of programmable regions, and an address inside a region is moved to that region's relocation base. Software leaves remap mode by writing one command register. From then on addresses pass through unchanged until the next reset. A typical use is to put boot code at address zero and later uncover the normal memory map.

A separate 32-bit register port programs the region table. It also provides a pause command that drives a halt output, a reset-cause status word whose bits software clears by writing ones, and an identification word. Translation is purely combinational. The downstream request therefore appears in the same cycle as the upstream request, and both channels share one valid/ready handshake. The upstream side sees back-pressure when the downstream side holds ready low: up_ready follows dn_ready. The requester must keep up_valid and its payload steady until up_ready is high. When the downstream side is marked absent, every request is accepted at once and flagged with an error. Nothing is forwarded in that case.

Top module: `boot_remap_ctrl`

## Requirements
- R1: After reset, remap mode is on, halt is low, the status word reads 0, and no region is programmed, so every address is forwarded unchanged.
- R2: In remap mode, an address A with start <= A <= end of an active region is forwarded as (A - start) + base.
- R3: Addresses outside every active region are forwarded unchanged.
- R4: Region bounds are inclusive. The address end+1 and the address start-1 are forwarded unchanged.
- R5: A region whose base was never written translates as identity, because the base reads back as its start. Writing a region's start again discards any base written earlier.
- R6: When active regions overlap, the region with the lowest index decides the translation.
- R7: A register write to offset 0x08, with any data, turns remap mode off. Addresses then pass unchanged whatever the table holds. Only reset turns remap mode back on.
- R8: A register write to offset 0x04 raises halt on the next clock edge. Halt stays high until reset.
- R9: Status bit k is set by a high on stat_set[k] and stays set. A register write to offset 0x14 clears the bits that are 1 in the written data. If a set and a clear hit the same bit in the same cycle, the set wins. A read of offset 0x10 returns the status word, zero-extended.
- R10: A read of offset 0x00 returns the identification parameter with bit 0 forced to 0.
- R11: While dn_present is low, an upstream request gets up_ready=1 and up_err=1 in the same cycle, and dn_valid stays low.
- R12: While dn_present is high, dn_valid equals up_valid and up_ready equals dn_ready, in the same cycle. dn_we and dn_wdata copy their upstream counterparts.
- R13: Region i occupies register offsets 0x40+16*i (start), +4 (end) and +8 (base). All three read back; the base reads as the effective base. A region becomes active once both its start and its end have been written. Reset clears the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_addr | input | 32 | Upstream address |
| up_we | input | 1 | Upstream write flag |
| up_wdata | input | 32 | Upstream write data |
| up_err | output | 1 | Request completes with error (no downstream) |
| dn_present | input | 1 | Downstream bus attached |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_addr | output | 32 | Translated address |
| dn_we | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write (else read) |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| stat_set | input | STAT_W | Reset-cause set pulses |
| halt | output | 1 | Pause request to the core clocking |

## Verification
The assertions assume that register strobes are single-cycle and synchronous, and that reg_addr is steady whenever reg_sel is high. They also assume the upstream requester obeys the valid/ready hold rule, so that comparing forwarded addresses in the same cycle is meaningful. The bench changes inputs only on the falling edge and holds each register strobe for exactly one rising edge. It keeps stat_set low except in cycles that deliberately test set-versus-clear priority, so each status expectation is determined by the bench's own writes.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // Field selector inside one region's 16-byte register window
  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_BASE = 2'd2,
    FLD_NONE = 2'd3
  } rgn_field_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic [ADDR_W-1:0] base;
    logic              has_lo;
    logic              has_hi;
    logic              has_base;
  } rgn_cfg_t;

  function automatic logic [ADDR_W-1:0] eff_base(rgn_cfg_t c);
    return c.has_base ? c.base : c.lo;
  endfunction
endpackage

// File: rtl/brp_region_bank.sv
module brp_region_bank
  import brp_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  rgn_field_e        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  output rgn_cfg_t          cfg [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    rgn_cfg_t r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= '0;
      end else if (wr_en && wr_idx == IDXW'(g)) begin
        unique case (wr_field)
          FLD_LO: begin
            r.lo       <= wr_data;
            r.has_lo   <= 1'b1;
            r.has_base <= 1'b0;
          end
          FLD_HI: begin
            r.hi     <= wr_data;
            r.has_hi <= 1'b1;
          end
          FLD_BASE: begin
            r.base     <= wr_data;
            r.has_base <= 1'b1;
          end
          default: ;
        endcase
      end
    end
    assign cfg[g] = r;
  end
endmodule

// File: rtl/brp_xlate.sv
module brp_xlate
  import brp_pkg::*;
#(
  parameter int NREG = 4
)(
  input  logic              remap_on,
  input  rgn_cfg_t          cfg [NREG],
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = cfg[g].has_lo && cfg[g].has_hi &&
                    (addr_in >= cfg[g].lo) && (addr_in <= cfg[g].hi);
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    addr_out = addr_in;
    if (remap_on) begin
      for (int i = 0; i < NREG; i++) begin
        if (!found && hit[i]) begin
          found    = 1'b1;
          addr_out = (addr_in - cfg[i].lo) + eff_base(cfg[i]);
        end
      end
    end
  end
endmodule

// File: rtl/brp_regport.sv
module brp_regport
  import brp_pkg::*;
#(
  parameter int              NREG     = 4,
  parameter int              STAT_W   = 8,
  parameter int              REG_AW   = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0000_B0A1,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] stat_set,
  input  rgn_cfg_t          cfg [NREG],
  output logic              bank_we,
  output logic [IDXW-1:0]   bank_idx,
  output rgn_field_e        bank_field,
  output logic              remap_on,
  output logic              halt,
  output logic [STAT_W-1:0] stat
);
  localparam logic [REG_AW-1:0] OFS_ID    = REG_AW'('h00);
  localparam logic [REG_AW-1:0] OFS_PAUSE = REG_AW'('h04);
  localparam logic [REG_AW-1:0] OFS_FLAT  = REG_AW'('h08);
  localparam logic [REG_AW-1:0] OFS_STAT  = REG_AW'('h10);
  localparam logic [REG_AW-1:0] OFS_CLR   = REG_AW'('h14);
  localparam logic [REG_AW:0]   RGN_FIRST = (REG_AW+1)'('h40);
  localparam logic [REG_AW:0]   RGN_LAST  = (REG_AW+1)'('h40 + 16*NREG);

  logic              wr;
  logic              in_rgn;
  logic [REG_AW-1:0] rel;
  logic [STAT_W-1:0] clr_mask;

  assign wr         = reg_sel & reg_we;
  assign in_rgn     = ({1'b0, reg_addr} >= RGN_FIRST) && ({1'b0, reg_addr} < RGN_LAST);
  assign rel        = reg_addr - RGN_FIRST[REG_AW-1:0];
  assign bank_idx   = rel[IDXW+3:4];
  assign bank_field = rgn_field_e'(rel[3:2]);
  assign bank_we    = wr && in_rgn;
  assign clr_mask   = (wr && reg_addr == OFS_CLR) ? reg_wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_on <= 1'b1;
      halt     <= 1'b0;
      stat     <= '0;
    end else begin
      if (wr && reg_addr == OFS_PAUSE) halt     <= 1'b1;
      if (wr && reg_addr == OFS_FLAT)  remap_on <= 1'b0;
      stat <= (stat & ~clr_mask) | stat_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_rgn) begin
      for (int i = 0; i < NREG; i++) begin
        if (bank_idx == IDXW'(i)) begin
          unique case (bank_field)
            FLD_LO:   reg_rdata = cfg[i].lo;
            FLD_HI:   reg_rdata = cfg[i].hi;
            FLD_BASE: reg_rdata = eff_base(cfg[i]);
            default:  reg_rdata = '0;
          endcase
        end
      end
    end else if (reg_addr == OFS_ID) begin
      reg_rdata = {ID_VALUE[DATA_W-1:1], 1'b0};
    end else if (reg_addr == OFS_STAT) begin
      reg_rdata = DATA_W'(stat);
    end
  end
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import brp_pkg::*;
#(
  parameter int                NREG     = 4,
  parameter int                STAT_W   = 8,
  parameter int                REG_AW   = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0000_B0A1,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_we,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_err,
  input  logic              dn_present,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_we,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] stat_set,
  output logic              halt
);
  rgn_cfg_t          cfg [NREG];
  logic              bank_we;
  logic [IDXW-1:0]   bank_idx;
  rgn_field_e        bank_field;
  logic              remap_on;
  logic [STAT_W-1:0] rst_stat;

  brp_regport #(
    .NREG(NREG), .STAT_W(STAT_W), .REG_AW(REG_AW), .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_set(stat_set),
    .cfg(cfg), .bank_we(bank_we), .bank_idx(bank_idx), .bank_field(bank_field),
    .remap_on(remap_on), .halt(halt), .stat(rst_stat)
  );

  brp_region_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bank_we), .wr_idx(bank_idx), .wr_field(bank_field),
    .wr_data(reg_wdata), .cfg(cfg)
  );

  brp_xlate #(.NREG(NREG)) u_xlate (
    .remap_on(remap_on), .cfg(cfg), .addr_in(up_addr), .addr_out(dn_addr)
  );

  // Request channel: a pass-through handshake, or an immediate error when
  // nothing is attached downstream.
  assign dn_valid = up_valid & dn_present;
  assign up_ready = dn_present ? dn_ready : 1'b1;
  assign up_err   = ~dn_present;
  assign dn_we    = up_we;
  assign dn_wdata = up_wdata;
endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
  parameter int STAT_W = 8,
  parameter int REG_AW = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic [31:0]       up_addr,
  input logic              up_err,
  input logic              dn_present,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [31:0]       dn_addr,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [STAT_W-1:0] stat_set,
  input logic              halt,
  input logic              remap_on,
  input logic [STAT_W-1:0] stat
);
  AST_FLAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_on |-> dn_addr == up_addr); // R7
  AST_FLAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_on |=> !remap_on); // R7
  AST_PAUSE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_addr == REG_AW'('h04)) |=> halt); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt); // R8
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_addr == REG_AW'('h14)) |=>
      ((stat & $past(reg_wdata[STAT_W-1:0]) & ~$past(stat_set)) == '0)); // R9
  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set != '0) |=> ((stat & $past(stat_set)) == $past(stat_set))); // R9
  AST_ID_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_we && reg_addr == REG_AW'('h00)) |-> !reg_rdata[0]); // R10
  AST_NO_DOWNSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_present && up_valid) |-> (up_ready && up_err && !dn_valid)); // R11
  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_present |-> (up_ready == dn_ready && dn_valid == up_valid && !up_err)); // R12
endmodule

bind boot_remap_ctrl brp_checker #(.STAT_W(STAT_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .up_addr(up_addr), .up_err(up_err), .dn_present(dn_present),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
  .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_set(stat_set),
  .halt(halt), .remap_on(remap_on), .stat(rst_stat)
);

// File: tb/boot_remap_ctrl_tb.sv
module boot_remap_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // Translation vectors, applied after the region table is programmed:
  // r0 [0x0,0xFFF]->0x8000_0000, r1 [0x1000_0000,0x1000_00FF]->0x2000_0000,
  // r2 [0x1000_0080,0x1000_01FF]->0x3000_0000, r3 [0x5000_0000,0x5000_0010] base unset
  localparam logic [31:0] VEC_IN [NVEC] = '{
    32'h0000_0000, // R2
    32'h0000_0FFF, // R4 last inside
    32'h0000_1000, // R4 end+1
    32'h1000_0090, // R6 overlap -> r1
    32'h1000_0100, // R6 only r2
    32'h1000_01FF, // R4 r2 last
    32'h1000_0200, // R4 r2 end+1
    32'h5000_0008, // R5 base unset
    32'h7777_0000, // R3 outside
    32'h0FFF_FFFF  // R4 r1 start-1
  };
  localparam logic [31:0] VEC_EXP [NVEC] = '{
    32'h8000_0000, 32'h8000_0FFF, 32'h0000_1000, 32'h2000_0090, 32'h3000_0080,
    32'h3000_017F, 32'h1000_0200, 32'h5000_0008, 32'h7777_0000, 32'h0FFF_FFFF
  };
  localparam int VEC_REQ [NVEC] = '{2, 4, 4, 6, 6, 4, 4, 5, 3, 4};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        up_valid, up_ready, up_we, up_err;
  logic [31:0] up_addr, up_wdata;
  logic        dn_present, dn_valid, dn_ready, dn_we;
  logic [31:0] dn_addr, dn_wdata;
  logic        reg_sel, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  stat_set;
  logic        halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_remap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_we(up_we), .up_wdata(up_wdata), .up_err(up_err),
    .dn_present(dn_present), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_we(dn_we), .dn_wdata(dn_wdata),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_set(stat_set), .halt(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic xl(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    up_addr = a;
    #1 d = dn_addr;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; up_valid = 1'b0; up_we = 1'b0; up_addr = '0; up_wdata = '0;
    dn_present = 1'b1; dn_ready = 1'b1; reg_sel = 1'b0; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; stat_set = '0;
    do_reset();

    // R1 reset state
    #1 chk("R1 halt", 32'(halt), 32'd0);
    reg_rd(8'h10, v); chk("R1 status", v, 32'd0);
    xl(32'h0000_0100, v); chk("R1 identity with empty table", v, 32'h0000_0100);

    // R10 identification
    reg_rd(8'h00, v); chk("R10 id", v, 32'h0000_B0A0);

    // program regions (R13 layout)
    reg_wr(8'h40, 32'h0000_0000); reg_wr(8'h44, 32'h0000_0FFF); reg_wr(8'h48, 32'h8000_0000);
    reg_wr(8'h50, 32'h1000_0000); reg_wr(8'h54, 32'h1000_00FF); reg_wr(8'h58, 32'h2000_0000);
    reg_wr(8'h60, 32'h1000_0080); reg_wr(8'h64, 32'h1000_01FF); reg_wr(8'h68, 32'h3000_0000);
    reg_wr(8'h70, 32'h5000_0000); reg_wr(8'h74, 32'h5000_0010);
    reg_rd(8'h44, v); chk("R13 end readback", v, 32'h0000_0FFF);
    reg_rd(8'h58, v); chk("R13 base readback", v, 32'h2000_0000);
    reg_rd(8'h78, v); chk("R13 R5 unset base reads start", v, 32'h5000_0000);

    for (int i = 0; i < NVEC; i++) begin
      xl(VEC_IN[i], v);
      chk($sformatf("R%0d vector %0d", VEC_REQ[i], i), v, VEC_EXP[i]);
    end

    // R5: written base applies, rewriting start drops it
    reg_wr(8'h78, 32'h6000_0000);
    xl(32'h5000_0008, v); chk("R5 base written", v, 32'h6000_0008);
    reg_wr(8'h70, 32'h5000_0000);
    xl(32'h5000_0008, v); chk("R5 start rewrite drops base", v, 32'h5000_0008);

    // R13: region active only after start and end; fresh table after reset is tested below
    // R12 handshake and payload
    @(negedge clk);
    up_valid = 1'b1; up_we = 1'b1; up_wdata = 32'hCAFE_0001; dn_ready = 1'b0;
    #1 chk("R12 back-pressure", {30'd0, up_ready, dn_valid}, 32'd1);
    chk("R12 wdata", dn_wdata, 32'hCAFE_0001);
    chk("R12 we", 32'(dn_we), 32'd1);
    @(negedge clk); dn_ready = 1'b1;
    #1 chk("R12 ready follows", {30'd0, up_ready, dn_valid}, 32'd3);

    // R11 no downstream
    @(negedge clk); dn_present = 1'b0;
    #1 chk("R11 err/ready/dn_valid", {29'd0, up_err, up_ready, dn_valid}, 32'd6);
    @(negedge clk); dn_present = 1'b1; up_valid = 1'b0; up_we = 1'b0;

    // R9 status set, W1C, set wins
    @(negedge clk); stat_set = 8'h0B;
    @(negedge clk); stat_set = 8'h00;
    reg_rd(8'h10, v); chk("R9 set", v, 32'h0000_000B);
    reg_wr(8'h14, 32'h0000_0003);
    reg_rd(8'h10, v); chk("R9 w1c", v, 32'h0000_0008);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0000_0009; stat_set = 8'h01;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; stat_set = 8'h00;
    reg_rd(8'h10, v); chk("R9 set wins", v, 32'h0000_0001);

    // R8 pause
    reg_wr(8'h04, 32'h0);
    #1 chk("R8 halt raised", 32'(halt), 32'd1);
    repeat (3) @(negedge clk);
    #1 chk("R8 halt held", 32'(halt), 32'd1);

    // R7 flat map
    reg_wr(8'h08, 32'h0);
    xl(32'h0000_0010, v); chk("R7 flat r0", v, 32'h0000_0010);
    xl(32'h1000_0090, v); chk("R7 flat r1", v, 32'h1000_0090);
    reg_wr(8'h08, 32'h0);
    xl(32'h0000_0FFF, v); chk("R7 still flat", v, 32'h0000_0FFF);

    // reset restores remap, clears halt and table
    do_reset();
    #1 chk("R8 halt cleared by reset", 32'(halt), 32'd0);
    xl(32'h0000_0010, v); chk("R13 table cleared", v, 32'h0000_0010);
    reg_wr(8'h40, 32'h0000_0000); reg_wr(8'h48, 32'h8000_0000);
    xl(32'h0000_0010, v); chk("R13 start only inactive", v, 32'h0000_0010);
    reg_wr(8'h44, 32'h0000_0FFF);
    xl(32'h0000_0010, v); chk("R7 remap back after reset", v, 32'h8000_0010);

    done = 1'b1;
    summary();
  end
endmodule